// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block links two 18-bit bidirectional buses, called A and B, and passes data across without inverting it. Each direction has its own controls and its own storage path. A level-sensitive pass enable chooses between a transparent path and a stored value. When pass is off, the stored value changes only on a rising edge of a capture strobe, and only if that direction's active-low clock enable allows it. An active-low output enable decides whether the direction drives its destination bus or leaves it at high impedance.

The model is synchronous. A single system clock samples both capture strobes, and a rising edge counts when a strobe is seen low on one sample and high on the next. The transparent path is combinational from the source bus to the destination bus. While pass is on, the stored value follows the input, so the last passed value stays on the output after pass drops. Only one side may drive a bus at any time. The system around the block must keep the two output enables from being active together.

Top module: `bus_xcvr_reg`

## Requirements
- R1: After reset, both stored values are zero and the strobe history reads as high, so a strobe that is high on the first sample is not taken as an edge.
- R2: While a direction's pass enable is 1, its destination bus equals its source bus in the same cycle, bit for bit and not inverted.
- R3: While pass enable is 0 and no rising strobe edge is taken, the output keeps the stored value, even when the source bus changes.
- R4: While pass enable is 0 and clock enable is 0, a strobe sampled 0 on one clock and 1 on the next clock loads the source bus at that second clock.
- R5: While clock enable is 1, rising strobe edges are ignored and the stored value does not change.
- R6: When pass enable falls, the output keeps the last value that was passed transparently.
- R7: When output enable is 1, the direction does not drive its destination bus, and an external driver's value appears unchanged on that bus. When output enable is 0, the direction drives the bus.
- R8: The A-to-B and B-to-A directions are independent. The controls of one direction have no effect on the value stored in the other.
- R9: The two output enables are never active in the same cycle. The surrounding system must uphold this, and the bench checks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the strobes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_io | inout | 18 | A bus |
| b_io | inout | 18 | B bus |
| le_ab_i | input | 1 | A-to-B pass enable |
| cp_ab_i | input | 1 | A-to-B capture strobe |
| ce_ab_ni | input | 1 | A-to-B clock enable, active low |
| oe_ab_ni | input | 1 | B bus output enable, active low |
| le_ba_i | input | 1 | B-to-A pass enable |
| cp_ba_i | input | 1 | B-to-A capture strobe |
| ce_ba_ni | input | 1 | B-to-A clock enable, active low |
| oe_ba_ni | input | 1 | A bus output enable, active low |

## Verification
The block is exercised in three bus patterns:
- **Bench drives A, block drives B.** This pattern shows the difference between the pass path and the stored path.
- **Bench drives B, block drives A.** This pattern shows the same difference in the reverse direction.
- **Bench drives both buses, block drives neither.** This pattern separates a released output from a driven one. Any drive from the block would corrupt the values the bench reads back.

In the first two patterns, the reverse direction samples the bus the block itself is driving, so its stored value shows whether a strobe of the other direction leaked across. Directed sequences place strobe edges with the clock enable on and off, drop pass enable after a run of passed values, and hold the strobe steady while the source data changes. These cases separate capture, hold, ignored edges and retained values.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  localparam int unsigned XCVR_W = 18;

  typedef enum logic [1:0] {
    ST_KEEP    = 2'd0,
    ST_PASS    = 2'd1,
    ST_CAPTURE = 2'd2
  } store_op_e;
endpackage

// File: rtl/xcvr_strobe_edge.sv
`timescale 1ns/1ps
module xcvr_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cp_i,
  input  logic ce_ni,
  output logic cap_o
);
  logic cp_q;

  // history resets high: a strobe already high at reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cp_q <= 1'b1;
    else         cp_q <= cp_i;
  end

  assign cap_o = cp_i & ~cp_q & ~ce_ni;

  p_edge_spaced_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o);
endmodule

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         le_i,
  input  logic         cp_i,
  input  logic         ce_ni,
  output logic [W-1:0] dout_o
);
  logic         cap;
  logic [W-1:0] q;
  store_op_e    op;

  xcvr_strobe_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cp_i  (cp_i),
    .ce_ni (ce_ni),
    .cap_o (cap)
  );

  always_comb begin
    if (le_i)     op = ST_PASS;
    else if (cap) op = ST_CAPTURE;
    else          op = ST_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else begin
      unique case (op)
        ST_PASS, ST_CAPTURE: q <= din_i;
        default:             q <= q;
      endcase
    end
  end

  assign dout_o = le_i ? din_i : q;

  p_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> q == $past(din_i));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !cap) |=> $stable(q));
  p_ce_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && ce_ni) |=> $stable(q));
  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && cap) |=> q == $past(din_i));
endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/1ps
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         le_ab_i,
  input  logic         cp_ab_i,
  input  logic         ce_ab_ni,
  input  logic         oe_ab_ni,
  input  logic         le_ba_i,
  input  logic         cp_ba_i,
  input  logic         ce_ba_ni,
  input  logic         oe_ba_ni
);
  logic [W-1:0] ab_out;
  logic [W-1:0] ba_out;

  xcvr_store #(.W(W)) u_ab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (a_io),
    .le_i  (le_ab_i),
    .cp_i  (cp_ab_i),
    .ce_ni (ce_ab_ni),
    .dout_o(ab_out)
  );

  xcvr_store #(.W(W)) u_ba (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (b_io),
    .le_i  (le_ba_i),
    .cp_i  (cp_ba_i),
    .ce_ni (ce_ba_ni),
    .dout_o(ba_out)
  );

  assign b_io = oe_ab_ni ? {W{1'bz}} : ab_out;
  assign a_io = oe_ba_ni ? {W{1'bz}} : ba_out;
endmodule

// File: tb/tb_bus_xcvr_reg.sv
`timescale 1ns/1ps
module tb_bus_xcvr_reg;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a_drv = '0, b_drv = '0;
  logic a_en = 1'b1, b_en = 1'b0;
  wire  [W-1:0] a_bus, b_bus;
  assign a_bus = a_en ? a_drv : {W{1'bz}};
  assign b_bus = b_en ? b_drv : {W{1'bz}};

  logic le_ab = 0, cp_ab = 0, ce_ab_n = 0, oe_ab_n = 0;
  logic le_ba = 0, cp_ba = 0, ce_ba_n = 0, oe_ba_n = 1;

  bus_xcvr_reg dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_io(a_bus), .b_io(b_bus),
    .le_ab_i(le_ab), .cp_ab_i(cp_ab), .ce_ab_ni(ce_ab_n), .oe_ab_ni(oe_ab_n),
    .le_ba_i(le_ba), .cp_ba_i(cp_ba), .ce_ba_ni(ce_ba_n), .oe_ba_ni(oe_ba_n)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_qab = '0, m_qba = '0;
  logic m_pab = 1'b1, m_pba = 1'b1;

  function automatic logic [W-1:0] f_out(logic le, logic [W-1:0] din, logic [W-1:0] q);
    return le ? din : q;
  endfunction

  function automatic logic [W-1:0] f_next(logic le, logic cp, logic prev, logic ce_n,
                                          logic [W-1:0] din, logic [W-1:0] q);
    if (le) return din;
    if (cp && !prev && !ce_n) return din;
    return q;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // mode 0: bench drives A, dut drives B; 1: reverse; 2: bench drives both
  task automatic cyc(string tag, int mode, logic lab, logic cab, logic eab,
                     logic lba, logic cba, logic eba, logic [W-1:0] d);
    logic [W-1:0] din_ab, din_ba, exp_a, exp_b;
    @(negedge clk);
    le_ab = lab; cp_ab = cab; ce_ab_n = eab;
    le_ba = lba; cp_ba = cba; ce_ba_n = eba;
    case (mode)
      0: begin a_en = 1; b_en = 0; a_drv = d; oe_ab_n = 0; oe_ba_n = 1; end
      1: begin b_en = 1; a_en = 0; b_drv = d; oe_ba_n = 0; oe_ab_n = 1; end
      default: begin a_en = 1; b_en = 1; a_drv = d; b_drv = ~d & MASK;
                     oe_ab_n = 1; oe_ba_n = 1; end
    endcase
    #2;
    checks++;
    if (!oe_ab_n && !oe_ba_n) begin
      errors++;
      $display("FAIL R9: actual both enables active expected at most one");
    end
    case (mode)
      0: begin din_ab = d; exp_b = f_out(lab, d, m_qab); din_ba = exp_b; exp_a = d; end
      1: begin din_ba = d; exp_a = f_out(lba, d, m_qba); din_ab = exp_a; exp_b = d; end
      default: begin din_ab = d; din_ba = ~d & MASK; exp_a = d; exp_b = ~d & MASK; end
    endcase
    check({tag, " A bus"}, a_bus, exp_a);
    check({tag, " B bus"}, b_bus, exp_b);
    @(posedge clk);
    m_qab = f_next(lab, cab, m_pab, eab, din_ab, m_qab);
    m_qba = f_next(lba, cba, m_pba, eba, din_ba, m_qba);
    m_pab = cab;
    m_pba = cba;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a1b));
    a_drv = 18'h2aaaa;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: zero after reset, strobe held high from reset is no edge
    cyc("R1", 0, 0, 1, 0, 0, 1, 0, 18'h3ffff);
    cyc("R1", 1, 0, 1, 0, 0, 1, 0, 18'h15555);
    // R2: transparent both ways
    cyc("R2", 0, 1, 0, 1, 0, 0, 1, 18'h12345);
    cyc("R2", 1, 0, 0, 1, 1, 0, 1, 18'h0abcd);
    // R6: pass falls, last passed value kept
    cyc("R6", 0, 1, 0, 1, 0, 0, 1, 18'h31f0f);
    cyc("R6", 0, 0, 0, 1, 0, 0, 1, 18'h00001);
    // R3: strobe steady low then high, data changing
    cyc("R3", 0, 0, 0, 0, 0, 0, 1, 18'h22222);
    cyc("R4", 0, 0, 1, 0, 0, 0, 1, 18'h1beef);
    cyc("R3", 0, 0, 1, 0, 0, 0, 1, 18'h00f00);
    cyc("R3", 0, 0, 1, 0, 0, 0, 1, 18'h3c3c3);
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 18'h11111);
    // R5: edge with clock enable high ignored
    cyc("R5", 0, 0, 1, 1, 0, 0, 1, 18'h2dead);
    cyc("R5", 0, 0, 0, 1, 0, 0, 1, 18'h0cafe);
    cyc("R4", 0, 0, 1, 0, 0, 0, 1, 18'h3face);
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 18'h00000);
    // R8: B-to-A capture from driven B bus while A-to-B holds
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 18'h01234);
    cyc("R8", 0, 0, 0, 0, 0, 1, 0, 18'h2f00d);
    cyc("R8", 1, 0, 0, 0, 0, 0, 0, 18'h05a5a);
    // R7: both released, external values survive
    cyc("R7", 2, 0, 0, 0, 0, 0, 0, 18'h1a2b3);
    cyc("R7", 2, 1, 1, 0, 1, 1, 0, 18'h3ffff);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0, 18'h00abc);

    for (int i = 0; i < 400; i++) begin
      int m;
      m = int'($urandom_range(0, 2));
      cyc("R2/R3/R4/R5/R7/R8 random", m,
          1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
          1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
          18'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule